// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a RISC core in which every procedure sees a 32-entry, 32-bit register space. Eight of those entries are globals that never move. The other twenty-four are mapped through a current window pointer onto a larger physical array. The window part holds three groups of eight registers: outgoing arguments, locals and incoming arguments. A procedure's outgoing group is the same storage as the incoming group of the procedure it calls, so arguments pass with no copying.

The core reads two operands through combinational ports and writes one result per cycle. All three ports are addressed with a 5-bit architectural register number. A call issues a save command, which moves the pointer one window down. A return issues a restore command, which moves it one window up. A mask of unavailable windows lets the trap logic stop a move into a window that has not been spilled or filled. In that case the block raises an overflow or underflow flag and leaves the pointer where it was. Spilling to memory and the trap handler lie outside the block.

Top module: `regwin_rf`

## Requirements
- R1: After synchronous reset, the window pointer is 0, both flags are low, and every architectural register reads 0 in every window.
- R2: Architectural register 0 always reads 0 on both read ports, and a write to it has no effect.
- R3: Registers 1–7 are globals: a value written in one window reads back unchanged at the same number in every other window.
- R4: Registers 16–23 are locals private to the current window: a write there is not visible at 16–23 from any other window.
- R5: Registers 8–15 of window w are the same storage as registers 24–31 of window w−1 (mod 8): number 8+k in the caller equals number 24+k in the callee.
- R6: A save (save_req=1) moves the pointer from w to (w−1) mod 8, and a restore (restore_req=1, save_req=0) moves it to (w+1) mod 8. The new pointer applies from the clock edge that samples the command.
- R7: A save whose target window has its bit set in win_invalid leaves the pointer unchanged and drives ovf_flag high for exactly the cycle after that edge.
- R8: A restore whose target window has its bit set in win_invalid leaves the pointer unchanged and drives unf_flag high for exactly the cycle after that edge.
- R9: When save_req and restore_req are high together, the save is performed and the restore is ignored.
- R10: Reads are combinational. A write becomes visible from the next cycle, and a read of the same register in the write cycle returns the old value. A write always uses the window that was current before that edge.
- R11: The two read ports are independent: each returns its own register in the same cycle, even when both name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Architectural number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Architectural number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural number to write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Call-style window move (pointer down) |
| restore_req | input | 1 | Return-style window move (pointer up) |
| win_invalid | input | 8 | One bit per window; 1 marks the window unavailable |
| cur_win | output | 3 | Current window pointer |
| ovf_flag | output | 1 | Pulse: a save was rejected |
| unf_flag | output | 1 | Pulse: a restore was rejected |

## Verification
Read data depends only on the present pointer, indices and stored contents, so it is due in the same cycle. The bench samples it 1 ns before the rising edge and compares it with a behavioural model. Writes, pointer moves and the two flags all land on the edge that samples the command. The bench updates its model at that edge and compares the pointer and flags 1 ns later, so each result is checked exactly one edge after its stimulus. Directed sequences cover the overlap, the wraparound, the rejections and the simultaneous-command case. A long pseudo-random run then compares every port with the model on every clock.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int XLEN    = 32;
    localparam int NWIN    = 8;
    localparam int GRP     = 8;
    localparam int NGRP    = 4;
    localparam int NARCH   = GRP * NGRP;
    localparam int IDXW    = $clog2(NARCH);
    localparam int SLOTW   = $clog2(GRP);
    localparam int WINW    = $clog2(NWIN);
    localparam int PER_WIN = 2 * GRP;
    localparam int NPHYS   = GRP + NWIN * PER_WIN;
    localparam int PHYW    = $clog2(NPHYS);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [IDXW-1:0] arch_idx_t;
    typedef logic [WINW-1:0] win_t;
    typedef logic [PHYW-1:0] phys_t;

    // group order is decoded from the two top index bits
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_SAVE    = 2'd1,
        CMD_RESTORE = 2'd2
    } win_cmd_e;

    typedef struct packed {
        reg_grp_e grp;
        logic     hardzero;
        phys_t    phys;
    } xlate_t;

    function automatic win_t win_dec(win_t w);
        if (int'(w) == 0) return win_t'(NWIN - 1);
        return win_t'(int'(w) - 1);
    endfunction

    function automatic win_t win_inc(win_t w);
        if (int'(w) == NWIN - 1) return win_t'(0);
        return win_t'(int'(w) + 1);
    endfunction

    function automatic reg_grp_e grp_of(arch_idx_t idx);
        return reg_grp_e'(idx[IDXW-1 -: 2]);
    endfunction

    // Each window owns its outs (slots 0..GRP-1) and locals (GRP..2*GRP-1);
    // its ins alias the outs owned by the next-higher window.
    function automatic phys_t phys_of(win_t cwp, arch_idx_t idx);
        int base;
        int slot;
        slot = int'(idx[SLOTW-1:0]);
        case (grp_of(idx))
            GRP_GLOBAL: base = 0;
            GRP_OUT:    base = GRP + int'(cwp) * PER_WIN;
            GRP_LOCAL:  base = GRP + int'(cwp) * PER_WIN + GRP;
            default:    base = GRP + int'(win_inc(cwp)) * PER_WIN;
        endcase
        return phys_t'(base + slot);
    endfunction

endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
    import regwin_pkg::*;
(
    input  win_t      cwp,
    input  arch_idx_t idx,
    output xlate_t    xl
);

    always_comb begin
        xl.grp      = grp_of(idx);
        xl.hardzero = (idx == '0);
        xl.phys     = phys_of(cwp, idx);
    end

endmodule

// File: rtl/regwin_win_ctrl.sv
module regwin_win_ctrl
    import regwin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_invalid,
    output win_t            cwp,
    output logic            ovf,
    output logic            unf
);

    win_cmd_e cmd;
    win_t     target;
    logic     blocked;

    always_comb begin
        if (save_req)         cmd = CMD_SAVE;
        else if (restore_req) cmd = CMD_RESTORE;
        else                  cmd = CMD_NONE;

        case (cmd)
            CMD_SAVE:    target = win_dec(cwp);
            CMD_RESTORE: target = win_inc(cwp);
            default:     target = cwp;
        endcase

        blocked = (cmd != CMD_NONE) && win_invalid[target];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= (cmd == CMD_SAVE) && blocked;
            unf <= (cmd == CMD_RESTORE) && blocked;
            if ((cmd != CMD_NONE) && !blocked)
                cwp <= target;
        end
    end

endmodule

// File: rtl/regwin_store.sv
module regwin_store
    import regwin_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  phys_t               waddr,
    input  word_t               wdata,
    input  phys_t [NRD-1:0]     raddr,
    output word_t [NRD-1:0]     rdata
);

    word_t mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/regwin_rf.sv
module regwin_rf
    import regwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [IDXW-1:0]     rd_a_idx,
    output logic [XLEN-1:0]     rd_a_data,
    input  logic [IDXW-1:0]     rd_b_idx,
    output logic [XLEN-1:0]     rd_b_data,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [XLEN-1:0]     wr_data,
    input  logic                save_req,
    input  logic                restore_req,
    input  logic [NWIN-1:0]     win_invalid,
    output logic [WINW-1:0]     cur_win,
    output logic                ovf_flag,
    output logic                unf_flag
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;
    localparam int WPORT = NRD;

    win_t                cwp;
    arch_idx_t [NPORT-1:0] port_idx;
    xlate_t    [NPORT-1:0] xl;
    phys_t     [NRD-1:0]   raddr;
    word_t     [NRD-1:0]   rdata;
    word_t     [NRD-1:0]   rdata_masked;
    logic                  we;

    assign port_idx[0]     = rd_a_idx;
    assign port_idx[1]     = rd_b_idx;
    assign port_idx[WPORT] = wr_idx;

    regwin_win_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .win_invalid (win_invalid),
        .cwp         (cwp),
        .ovf         (ovf_flag),
        .unf         (unf_flag)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_xl
        regwin_xlate u_xl (
            .cwp (cwp),
            .idx (port_idx[g]),
            .xl  (xl[g])
        );
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rp
        assign raddr[g]        = xl[g].phys;
        assign rdata_masked[g] = xl[g].hardzero ? '0 : rdata[g];
    end

    assign we = wr_en && !xl[WPORT].hardzero;

    regwin_store #(.NRD(NRD)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (xl[WPORT].phys),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign rd_a_data = rdata_masked[0];
    assign rd_b_data = rdata_masked[1];
    assign cur_win   = cwp;

endmodule

// File: rtl/regwin_rf_chk.sv
module regwin_rf_chk
    import regwin_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [IDXW-1:0]     rd_a_idx,
    input logic [XLEN-1:0]     rd_a_data,
    input logic [IDXW-1:0]     rd_b_idx,
    input logic [XLEN-1:0]     rd_b_data,
    input logic                save_req,
    input logic                restore_req,
    input logic [NWIN-1:0]     win_invalid,
    input logic [WINW-1:0]     cur_win,
    input logic                ovf_flag,
    input logic                unf_flag
);

    win_t dn_win;
    win_t up_win;
    assign dn_win = win_dec(cur_win);
    assign up_win = win_inc(cur_win);

    // R6 / R9: an accepted save moves down, whatever restore_req does
    a_r6_save_step: assert property (@(posedge clk) disable iff (rst)
        (save_req && !win_invalid[dn_win]) |=> (cur_win == $past(dn_win)));

    // R6
    a_r6_restore_step: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !win_invalid[up_win]) |=> (cur_win == $past(up_win)));

    // R7
    a_r7_overflow: assert property (@(posedge clk) disable iff (rst)
        (save_req && win_invalid[dn_win]) |=> (ovf_flag && $stable(cur_win)));

    // R8
    a_r8_underflow: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && win_invalid[up_win]) |=> (unf_flag && $stable(cur_win)));

    // R9: a restore paired with a save never raises underflow
    a_r9_save_wins: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req) |=> !unf_flag);

    // R6: with no command the pointer holds and no flag is raised
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!save_req && !restore_req) |=> ($stable(cur_win) && !ovf_flag && !unf_flag));

    // R2
    a_r2_zero_a: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    a_r2_zero_b: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == '0) |-> (rd_b_data == '0));

endmodule

bind regwin_rf regwin_rf_chk u_chk (.*);

// File: tb/regwin_rf_tb_top.sv
module regwin_rf_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, save_req, restore_req;
    logic [7:0]  win_invalid;
    logic [2:0]  cur_win;
    logic        ovf_flag, unf_flag;

    always #5 clk = ~clk;

    regwin_rf dut_i (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .win_invalid(win_invalid), .cur_win(cur_win),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    // behavioural model: globals, per-window outs and locals
    logic [31:0] m_glob [8];
    logic [31:0] m_out  [8][8];
    logic [31:0] m_loc  [8][8];
    int          m_cwp;
    bit          m_ovf, m_unf;

    function automatic logic [31:0] m_read(int w, int idx);
        if (idx == 0)  return 32'h0;
        if (idx < 8)   return m_glob[idx];
        if (idx < 16)  return m_out[w][idx-8];
        if (idx < 24)  return m_loc[w][idx-16];
        return m_out[(w+1)%8][idx-24];
    endfunction

    function automatic string req_of(int idx);
        if (idx == 0)  return "R2";
        if (idx < 8)   return "R3";
        if (idx < 16)  return "R5";
        if (idx < 24)  return "R4";
        return "R5";
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 8; i++) begin
            m_glob[i] = '0;
            for (int j = 0; j < 8; j++) begin
                m_out[i][j] = '0;
                m_loc[i][j] = '0;
            end
        end
        m_cwp = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic m_clock(bit sv, bit rs, bit we, int wi, logic [31:0] wd, logic [7:0] inv);
        int tgt;
        if (we && wi != 0) begin
            if (wi < 8)       m_glob[wi] = wd;
            else if (wi < 16) m_out[m_cwp][wi-8] = wd;
            else if (wi < 24) m_loc[m_cwp][wi-16] = wd;
            else              m_out[(m_cwp+1)%8][wi-24] = wd;
        end
        m_ovf = 0; m_unf = 0;
        if (sv) begin
            tgt = (m_cwp + 7) % 8;
            if (inv[tgt]) m_ovf = 1; else m_cwp = tgt;
        end else if (rs) begin
            tgt = (m_cwp + 1) % 8;
            if (inv[tgt]) m_unf = 1; else m_cwp = tgt;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, check reads before edge, pointer/flags after
    task automatic step(bit sv, bit rs, bit we, int wi, logic [31:0] wd, int ra, int rb);
        save_req = sv; restore_req = rs; wr_en = we;
        wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
        #4;
        check({req_of(ra), " R10 port A"}, rd_a_data, m_read(m_cwp, ra));
        check({req_of(rb), " R11 port B"}, rd_b_data, m_read(m_cwp, rb));
        @(posedge clk);
        m_clock(sv, rs, we, wi, wd, win_invalid);
        #1;
        check("R6 pointer", 32'(cur_win), 32'(m_cwp));
        check("R7 ovf", 32'(ovf_flag), 32'(m_ovf));
        check("R8 unf", 32'(unf_flag), 32'(m_unf));
        @(negedge clk);
    endtask

    task automatic idle_read(int ra, int rb);
        step(0, 0, 0, 0, 32'h0, ra, rb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; save_req = 0; restore_req = 0;
        wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0; win_invalid = '0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        check("R1 cur_win", 32'(cur_win), 32'd0);
        check("R1 ovf", 32'(ovf_flag), 32'd0);
        check("R1 unf", 32'(unf_flag), 32'd0);
        for (int i = 1; i < 32; i += 5) begin
            rd_a_idx = 5'(i); #1;
            check("R1 reg zero", rd_a_data, 32'h0);
        end
        #2;
        @(negedge clk);

        // R2: write to register 0 ignored
        step(0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0);
        idle_read(0, 0);
        check("R2 r0 port A", rd_a_data, 32'h0);

        // R10: same-cycle read returns old value, new one next cycle
        save_req = 0; restore_req = 0; wr_en = 1; wr_idx = 5; wr_data = 32'h1111_0005;
        rd_a_idx = 5; rd_b_idx = 5; #4;
        check("R10 old value", rd_a_data, 32'h0);
        check("R11 both ports", rd_b_data, 32'h0);
        @(posedge clk); m_clock(0, 0, 1, 5, 32'h1111_0005, win_invalid); #1;
        wr_en = 0;
        check("R10 new value", rd_a_data, 32'h1111_0005);
        @(negedge clk);

        // R5: out 9 written in window 0 appears as in 25 of window 7
        step(0, 0, 1, 9, 32'hCAFE_0009, 9, 5);
        step(0, 0, 1, 17, 32'h0A0A_0017, 17, 9);
        step(1, 0, 0, 0, 32'h0, 0, 0);
        check("R6 save wraps 0->7", 32'(cur_win), 32'd7);
        idle_read(25, 5);
        check("R5 overlap", rd_a_data, 32'hCAFE_0009);
        check("R3 global", rd_b_data, 32'h1111_0005);
        // R4: locals of window 7 are not window 0's
        idle_read(17, 9);
        check("R4 private local", rd_a_data, 32'h0);
        // write callee in, back to caller: caller out sees it
        step(0, 0, 1, 26, 32'h7777_001A, 26, 0);
        step(0, 1, 0, 0, 32'h0, 0, 0);
        check("R6 restore wraps 7->0", 32'(cur_win), 32'd0);
        idle_read(10, 17);
        check("R5 in->out", rd_a_data, 32'h7777_001A);
        check("R4 local kept", rd_b_data, 32'h0A0A_0017);

        // R7: save into invalid window
        win_invalid = 8'b1000_0000;
        step(1, 0, 0, 0, 32'h0, 0, 0);
        check("R7 ovf pulse", 32'(ovf_flag), 32'd1);
        check("R7 pointer held", 32'(cur_win), 32'd0);
        idle_read(0, 0);
        check("R7 pulse one cycle", 32'(ovf_flag), 32'd0);

        // R8: restore into invalid window
        win_invalid = 8'b0000_0010;
        step(0, 1, 0, 0, 32'h0, 0, 0);
        check("R8 unf pulse", 32'(unf_flag), 32'd1);
        check("R8 pointer held", 32'(cur_win), 32'd0);
        idle_read(0, 0);
        check("R8 pulse one cycle", 32'(unf_flag), 32'd0);

        // R9: both commands -> save
        win_invalid = '0;
        step(1, 1, 0, 0, 32'h0, 0, 0);
        check("R9 save wins", 32'(cur_win), 32'd7);
        check("R9 no unf", 32'(unf_flag), 32'd0);

        // random run against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit sv, rs, we;
            if (n % 64 == 0)
                win_invalid = 8'($urandom) & 8'($urandom) & 8'($urandom);
            r  = int'($urandom % 16);
            sv = (r == 0) || (r == 2);
            rs = (r == 1) || (r == 2);
            we = !sv && !rs && ($urandom % 3 != 0);
            step(sv, rs, we, int'($urandom % 32), $urandom,
                 int'($urandom % 32), int'($urandom % 32));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule